// File: doc/BRIEF.md
# Self-Refresh Entry and Exit Sequencer

This block sits between a DDR SDRAM controller's command scheduler and the memory pins. During normal operation it passes the scheduler's command word through unchanged and holds the clock enable high. When the controller raises a level request, the block issues a refresh-encoded command in the same cycle that it drops the clock enable. The memory then holds its contents on its own. For as long as the request stays high, the block keeps the clock enable low and drives NOP.

When the request falls, the block waits until the controller reports that the memory clock is stable. Only then does it raise the clock enable. It then forces NOPs for a programmable exit window. After that window, commands other than READ are released. READ stays blocked until a longer DLL relock count has elapsed since the clock enable rose. A build-time option merges both waits into a single all-NOP window of the relock length. Two handshake outputs tell the scheduler which command classes it may issue. A one-cycle pulse marks the end of the exit sequence.

Top module: `sr_sequencer`

## Requirements
- R1: After reset, cke_o is 1, cmd_ready_o and rd_ready_o are 1, and sr_active_o and exit_done_o are 0.
- R2: In normal operation (cke_o=1, rd_ready_o=1, exit_done_o=0), a sampled sr_req_i=1 produces, in the next cycle, cke_o=0 and cmd_o=4'b0001. The command bits are {cs_n,ras_n,cas_n,we_n}, so this is the refresh encoding. Both ready outputs are 0 in that cycle.
- R3: After the entry cycle, while sr_req_i stays 1, cke_o stays 0, cmd_o is NOP (4'b0111) whatever host_cmd_i and clk_stable_i are, sr_active_o is 1, and both ready outputs are 0.
- R4: Once sr_req_i is sampled 0 in self-refresh, cke_o stays 0 (sr_active_o 1, NOP) until clk_stable_i is sampled 1. cke_o rises in the following cycle.
- R5: For the first T_XSNR cycles with cke_o high after exit, cmd_o is NOP (4'b0111) and both ready outputs are 0.
- R6: From cycle T_XSNR to cycle DLL_CYC-1 after the rise, cmd_ready_o=1 and rd_ready_o=0. Non-READ host commands pass unchanged. A READ (4'b0101) is replaced by NOP.
- R7: In cycle DLL_CYC after the rise, exit_done_o is 1 for that single cycle, both ready outputs are 1, and every command passes. Normal operation follows.
- R8: With CONSERVATIVE=1, all DLL_CYC cycles after the rise force NOP with cmd_ready_o=0. Release happens at once in cycle DLL_CYC.
- R9: sr_req_i is ignored outside normal operation. A request raised while the block waits for clock stability or runs the exit windows neither shortens nor restarts the sequence. Entry happens only after the cycle that follows exit_done_o.
- R10: In normal operation, every host_cmd_i value, including READ and refresh, appears unchanged on cmd_o in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_req_i | input | 1 | Level request to be in self-refresh |
| clk_stable_i | input | 1 | Memory clock reported stable |
| host_cmd_i | input | 4 | Scheduler command {cs_n,ras_n,cas_n,we_n} |
| cke_o | output | 1 | Clock enable to the memory |
| cmd_o | output | 4 | Command to the memory {cs_n,ras_n,cas_n,we_n} |
| cmd_ready_o | output | 1 | Non-READ commands may be issued |
| rd_ready_o | output | 1 | READ commands may be issued |
| sr_active_o | output | 1 | Memory is held in self-refresh |
| exit_done_o | output | 1 | One-cycle pulse at the end of exit |

## Verification
The hardest situation to reach is a READ arriving at the exact boundary cycles. These are the last cycle of the relock window, where the READ must become NOP, and the first released cycle, where it must pass. A request re-raised in the middle of the exit windows is also hard to reach. A directed phase holds READ on host_cmd_i through a whole exit, so every boundary cycle sees it. A random phase with a slowly toggling request and a sparse clock-stable flag then drives both a normal and a merged-wait instance through many exits, including requests that land mid-exit.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

    typedef enum logic [2:0] {
        SR_IDLE,
        SR_ENTER,
        SR_IN_SR,
        SR_WAIT_CLK,
        SR_NOP_XSNR,
        SR_DLL_WAIT,
        SR_READY
    } sr_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } ddr_cmd_t;

    typedef enum logic [1:0] {
        SRC_HOST,
        SRC_NOP,
        SRC_REF
    } cmd_src_e;

    typedef struct packed {
        logic     cke;
        logic     cmd_open;
        logic     rd_open;
        logic     sr_active;
        logic     done;
        logic     gate_rd;
        cmd_src_e src;
    } sr_ctl_t;

    localparam ddr_cmd_t CMD_NOP     = ddr_cmd_t'(4'b0111);
    localparam ddr_cmd_t CMD_REFRESH = ddr_cmd_t'(4'b0001);
    localparam ddr_cmd_t CMD_READ    = ddr_cmd_t'(4'b0101);

    function automatic logic is_read(input ddr_cmd_t c);
        return (c == CMD_READ);
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic sr_ctl_t ctl_of_state(input sr_state_e st);
        sr_ctl_t c;
        c = '{cke: 1'b1, cmd_open: 1'b0, rd_open: 1'b0, sr_active: 1'b0,
              done: 1'b0, gate_rd: 1'b0, src: SRC_NOP};
        case (st)
            SR_IDLE: begin
                c.cmd_open = 1'b1;
                c.rd_open  = 1'b1;
                c.src      = SRC_HOST;
            end
            SR_ENTER: begin
                c.cke = 1'b0;
                c.src = SRC_REF;
            end
            SR_IN_SR, SR_WAIT_CLK: begin
                c.cke       = 1'b0;
                c.sr_active = 1'b1;
            end
            SR_NOP_XSNR: begin
                c.src = SRC_NOP;
            end
            SR_DLL_WAIT: begin
                c.cmd_open = 1'b1;
                c.gate_rd  = 1'b1;
                c.src      = SRC_HOST;
            end
            SR_READY: begin
                c.cmd_open = 1'b1;
                c.rd_open  = 1'b1;
                c.done     = 1'b1;
                c.src      = SRC_HOST;
            end
            default: c.src = SRC_NOP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sr_exit_timer.sv
module sr_exit_timer
    import sr_seq_pkg::*;
#(
    parameter int unsigned NOP_LEN = 10,
    parameter int unsigned DLL_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic nop_last,
    output logic dll_last
);
    localparam int unsigned MAX_CNT = max_u(NOP_LEN, DLL_CYC);
    localparam int unsigned CNT_W   = (MAX_CNT < 2) ? 1 : $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] NOP_END = CNT_W'(NOP_LEN - 1);
    localparam logic [CNT_W-1:0] DLL_END = CNT_W'(DLL_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Counts cycles since the clock enable rose; held at zero while idle.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != {CNT_W{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign nop_last = run && (cnt_q == NOP_END);
    assign dll_last = run && (cnt_q == DLL_END);

endmodule

// File: rtl/sr_fsm.sv
module sr_fsm
    import sr_seq_pkg::*;
#(
    parameter bit SKIP_DLL = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sr_req,
    input  logic      clk_stable,
    input  logic      nop_last,
    input  logic      dll_last,
    output sr_state_e state,
    output logic      timer_run
);
    sr_state_e state_q, state_d;
    sr_state_e after_nop;

    generate
        if (SKIP_DLL) begin : g_merged
            assign after_nop = SR_READY;
        end else begin : g_split
            assign after_nop = SR_DLL_WAIT;
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        case (state_q)
            SR_IDLE:     if (sr_req)     state_d = SR_ENTER;
            SR_ENTER:                    state_d = SR_IN_SR;
            SR_IN_SR:    if (!sr_req)    state_d = SR_WAIT_CLK;
            SR_WAIT_CLK: if (clk_stable) state_d = SR_NOP_XSNR;
            SR_NOP_XSNR: if (nop_last)   state_d = after_nop;
            SR_DLL_WAIT: if (dll_last)   state_d = SR_READY;
            SR_READY:                    state_d = SR_IDLE;
            default:                     state_d = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state     = state_q;
    assign timer_run = (state_q == SR_NOP_XSNR) || (state_q == SR_DLL_WAIT);

endmodule

// File: rtl/sr_cmd_gate.sv
module sr_cmd_gate
    import sr_seq_pkg::*;
(
    input  sr_ctl_t  ctl,
    input  ddr_cmd_t host_cmd,
    output ddr_cmd_t mem_cmd
);
    always_comb begin
        case (ctl.src)
            SRC_HOST: mem_cmd = (ctl.gate_rd && is_read(host_cmd)) ? CMD_NOP : host_cmd;
            SRC_REF:  mem_cmd = CMD_REFRESH;
            default:  mem_cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/sr_sequencer.sv
module sr_sequencer
    import sr_seq_pkg::*;
#(
    parameter int unsigned T_XSNR       = 10,
    parameter int unsigned DLL_CYC      = 200,
    parameter bit          CONSERVATIVE = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sr_req_i,
    input  logic       clk_stable_i,
    input  logic [3:0] host_cmd_i,
    output logic       cke_o,
    output logic [3:0] cmd_o,
    output logic       cmd_ready_o,
    output logic       rd_ready_o,
    output logic       sr_active_o,
    output logic       exit_done_o
);
    localparam int unsigned NOP_LEN  = CONSERVATIVE ? DLL_CYC : T_XSNR;
    localparam bit          SKIP_DLL = CONSERVATIVE || (T_XSNR >= DLL_CYC);

    sr_state_e state;
    logic      timer_run;
    logic      nop_last;
    logic      dll_last;
    sr_ctl_t   ctl;
    ddr_cmd_t  mem_cmd;

    sr_fsm #(.SKIP_DLL(SKIP_DLL)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sr_req     (sr_req_i),
        .clk_stable (clk_stable_i),
        .nop_last   (nop_last),
        .dll_last   (dll_last),
        .state      (state),
        .timer_run  (timer_run)
    );

    sr_exit_timer #(.NOP_LEN(NOP_LEN), .DLL_CYC(DLL_CYC)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (timer_run),
        .nop_last (nop_last),
        .dll_last (dll_last)
    );

    assign ctl = ctl_of_state(state);

    sr_cmd_gate u_gate (
        .ctl      (ctl),
        .host_cmd (ddr_cmd_t'(host_cmd_i)),
        .mem_cmd  (mem_cmd)
    );

    assign cke_o       = ctl.cke;
    assign cmd_o       = mem_cmd;
    assign cmd_ready_o = ctl.cmd_open;
    assign rd_ready_o  = ctl.rd_open;
    assign sr_active_o = ctl.sr_active;
    assign exit_done_o = ctl.done;

endmodule

// File: rtl/sr_sequencer_chk.sv
module sr_sequencer_chk #(
    parameter int unsigned DLL_CYC      = 200,
    parameter bit          CONSERVATIVE = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       sr_req_i,
    input logic       clk_stable_i,
    input logic       cke_o,
    input logic [3:0] cmd_o,
    input logic       cmd_ready_o,
    input logic       rd_ready_o,
    input logic       sr_active_o,
    input logic       exit_done_o
);
    localparam int unsigned W = $clog2(DLL_CYC + 2);
    localparam logic [W-1:0] SAT = W'(DLL_CYC + 1);

    logic [W-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !cke_o) begin
            hi_cnt <= '0;
        end else if (hi_cnt != SAT) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R1: read permission implies general permission and a running clock
    a_r1_ready_order: assert property (@(posedge clk) disable iff (rst)
        rd_ready_o |-> (cmd_ready_o && cke_o));

    // R2: entry drops the clock enable together with the refresh encoding
    a_r2_enter_refresh: assert property (@(posedge clk) disable iff (rst)
        (cke_o && rd_ready_o && !exit_done_o && sr_req_i)
        |=> (!cke_o && cmd_o == 4'b0001));

    // R3: while held in self-refresh only NOP is driven
    a_r3_hold_nop: assert property (@(posedge clk) disable iff (rst)
        (sr_active_o && !cke_o) |-> (cmd_o == 4'b0111));

    // R4: clock enable cannot rise without a stable clock
    a_r4_wait_stable: assert property (@(posedge clk) disable iff (rst)
        (sr_active_o && !clk_stable_i) |=> !cke_o);

    // R5: exit window with nothing released drives NOP
    a_r5_xsnr_nop: assert property (@(posedge clk) disable iff (rst)
        (cke_o && !cmd_ready_o) |-> (cmd_o == 4'b0111));

    // R6: no READ reaches the memory while reads are blocked
    a_r6_read_gated: assert property (@(posedge clk) disable iff (rst)
        !rd_ready_o |-> (cmd_o != 4'b0101));

    // R7: completion is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        exit_done_o |=> !exit_done_o);

    // R7: completion lands exactly DLL_CYC cycles after the clock enable rose
    a_r7_done_window: assert property (@(posedge clk) disable iff (rst)
        exit_done_o |-> (hi_cnt == W'(DLL_CYC)));

    generate
        if (CONSERVATIVE) begin : g_cons
            // R8: merged wait keeps every command class closed
            a_r8_merged_wait: assert property (@(posedge clk) disable iff (rst)
                (cke_o && !rd_ready_o) |-> (!cmd_ready_o && cmd_o == 4'b0111));
        end
    endgenerate

endmodule

bind sr_sequencer sr_sequencer_chk #(
    .DLL_CYC      (DLL_CYC),
    .CONSERVATIVE (CONSERVATIVE)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sr_req_i     (sr_req_i),
    .clk_stable_i (clk_stable_i),
    .cke_o        (cke_o),
    .cmd_o        (cmd_o),
    .cmd_ready_o  (cmd_ready_o),
    .rd_ready_o   (rd_ready_o),
    .sr_active_o  (sr_active_o),
    .exit_done_o  (exit_done_o)
);

// File: tb/test_sr_sequencer.sv
`timescale 1ns/1ps
module test_sr_sequencer;

    localparam int T_XSNR  = 10;
    localparam int DLL_CYC = 200;

    localparam int S_IDLE = 0, S_ENTER = 1, S_IN = 2, S_WAIT = 3,
                   S_NOP = 4, S_DLL = 5, S_READY = 6;

    localparam logic [3:0] C_NOP   = 4'b0111;
    localparam logic [3:0] C_REF   = 4'b0001;
    localparam logic [3:0] C_READ  = 4'b0101;
    localparam logic [3:0] C_WRITE = 4'b0100;
    localparam logic [3:0] C_ACT   = 4'b0011;
    localparam logic [3:0] C_PRE   = 4'b0010;
    localparam logic [3:0] C_DESEL = 4'b1111;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sr_req = 1'b0;
    logic       clk_stable = 1'b0;
    logic [3:0] host_cmd = 4'b0111;

    logic       cke    [2];
    logic [3:0] cmd    [2];
    logic       cready [2];
    logic       rready [2];
    logic       active [2];
    logic       done   [2];

    int m_state [2];
    int m_k     [2];
    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sr_sequencer #(.T_XSNR(T_XSNR), .DLL_CYC(DLL_CYC), .CONSERVATIVE(1'b0)) i_sr_sequencer (
        .clk(clk), .rst(rst), .sr_req_i(sr_req), .clk_stable_i(clk_stable),
        .host_cmd_i(host_cmd), .cke_o(cke[0]), .cmd_o(cmd[0]),
        .cmd_ready_o(cready[0]), .rd_ready_o(rready[0]),
        .sr_active_o(active[0]), .exit_done_o(done[0])
    );

    sr_sequencer #(.T_XSNR(T_XSNR), .DLL_CYC(DLL_CYC), .CONSERVATIVE(1'b1)) i_sr_sequencer_cons (
        .clk(clk), .rst(rst), .sr_req_i(sr_req), .clk_stable_i(clk_stable),
        .host_cmd_i(host_cmd), .cke_o(cke[1]), .cmd_o(cmd[1]),
        .cmd_ready_o(cready[1]), .rd_ready_o(rready[1]),
        .sr_active_o(active[1]), .exit_done_o(done[1])
    );

    function automatic string tag_of(int st, int mode, bit req);
        if (req && (st == S_WAIT || st == S_NOP || st == S_DLL || st == S_READY)) return "R9";
        case (st)
            S_IDLE:  return "R10";
            S_ENTER: return "R2";
            S_IN:    return "R3";
            S_WAIT:  return "R4";
            S_NOP:   return (mode == 1) ? "R8" : "R5";
            S_DLL:   return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [9:0] expect_of(int st, logic [3:0] hc);
        // {cke, cmd[3:0], cready, rready, active, done, pad}
        case (st)
            S_IDLE:  return {1'b1, hc,    1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
            S_ENTER: return {1'b0, C_REF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
            S_IN, S_WAIT:
                     return {1'b0, C_NOP, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
            S_NOP:   return {1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
            S_DLL:   return {1'b1, (hc == C_READ) ? C_NOP : hc, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
            default: return {1'b1, hc,    1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
        endcase
    endfunction

    task automatic check_outputs(string force_tag);
        for (int m = 0; m < 2; m++) begin
            logic [9:0] exp_v;
            logic [9:0] act_v;
            string t;
            exp_v = expect_of(m_state[m], host_cmd);
            act_v = {cke[m], cmd[m], cready[m], rready[m], active[m], done[m], 1'b0};
            t = (force_tag != "") ? force_tag : tag_of(m_state[m], m, sr_req);
            vectors++;
            if (act_v !== exp_v) begin
                miscompares++;
                $display("FAIL %s inst%0d state%0d k=%0d: actual {cke,cmd,crdy,rrdy,act,done}=%b expected %b",
                         t, m, m_state[m], m_k[m], act_v[9:1], exp_v[9:1]);
            end
        end
    endtask

    task automatic model_step();
        for (int m = 0; m < 2; m++) begin
            int nlen;
            nlen = (m == 1) ? DLL_CYC : T_XSNR;
            case (m_state[m])
                S_IDLE:  if (sr_req) m_state[m] = S_ENTER;
                S_ENTER: m_state[m] = S_IN;
                S_IN:    if (!sr_req) m_state[m] = S_WAIT;
                S_WAIT:  if (clk_stable) begin m_state[m] = S_NOP; m_k[m] = 0; end
                S_NOP: begin
                    m_k[m]++;
                    if (m_k[m] == nlen) m_state[m] = (nlen >= DLL_CYC) ? S_READY : S_DLL;
                end
                S_DLL: begin
                    m_k[m]++;
                    if (m_k[m] == DLL_CYC) m_state[m] = S_READY;
                end
                default: m_state[m] = S_IDLE;
            endcase
        end
    endtask

    // Inputs are set just after the falling edge, outputs compared 1 ns later.
    task automatic step(bit req, bit stab, logic [3:0] hc, string force_tag);
        sr_req = req;
        clk_stable = stab;
        host_cmd = hc;
        #1;
        check_outputs(force_tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    function automatic logic [3:0] rand_cmd();
        case ($urandom % 7)
            0: return C_NOP;
            1: return C_READ;
            2: return C_WRITE;
            3: return C_ACT;
            4: return C_PRE;
            5: return C_REF;
            default: return C_DESEL;
        endcase
    endfunction

    initial begin
        bit r;
        void'($urandom(32'h5EED_0042));
        for (int m = 0; m < 2; m++) begin m_state[m] = S_IDLE; m_k[m] = 0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state with a NOP and with a READ on the host side
        step(1'b0, 1'b0, C_NOP, "R1");
        step(1'b0, 1'b0, C_READ, "R1");
        // R10: pass-through of every command class in normal operation
        step(1'b0, 1'b0, C_REF, "R10");
        step(1'b0, 1'b0, C_WRITE, "R10");

        // Directed exit with READ held on every cycle: R2 R3 R4 R5 R6 R7
        step(1'b1, 1'b0, C_READ, "");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, C_READ, "");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, C_READ, "");
        for (int i = 0; i < DLL_CYC + 3; i++) step(1'b0, 1'b1, C_READ, "");

        // R9: request re-raised during the exit windows is ignored
        step(1'b1, 1'b0, C_NOP, "");
        step(1'b1, 1'b0, C_NOP, "");
        step(1'b0, 1'b0, C_NOP, "");
        step(1'b1, 1'b1, C_WRITE, "R9");
        for (int i = 0; i < DLL_CYC + 4; i++) step(1'b1, 1'b0, rand_cmd(), "");

        // Random phase
        r = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            if ($urandom % 80 == 0) r = ~r;
            step(r, ($urandom % 6) == 0, rand_cmd(), "");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual run still going, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule